// File: doc/BRIEF.md
# Receive Timestamp Latch Bank

This block stamps received precision-time event frames. A frame classifier upstream presents one strobe per frame with three fields: the protocol version (1 or 2), whether the frame arrived over UDP or directly over layer 2, and the message type. When the frame passes the configured filter and the bank is enabled, the live 64-bit nanosecond time is copied into a free slot. The slot number comes back with a capture-valid pulse, so the receive path can attach it to the frame and software can later fetch the matching pair of words.

There are four slots by default. A slot stays occupied until software reads its upper word, which frees it. A status word shows which slots are occupied. The filter selects one version at a time. It has a UDP recognition switch and a message-type match value for each version. Version 1 frames are only recognised over UDP, so choosing version 1 with UDP recognition off stops all captures. This is the nearest setting to "off" the filter provides.

Top module: `rx_stamp_bank`

## Requirements
- R1: After synchronous reset, no slot is occupied (the status word reads 0) and `cap_valid` is low.
- R2: With `cfg_ver`=0 (version 1 selected), a frame qualifies only if `frm_ver`=0, `frm_udp`=1, `cfg_udp_en`=1 and all 8 bits of `frm_type` equal `cfg_v1_type`.
- R3: With `cfg_ver`=1 (version 2 selected), a frame qualifies only if `frm_ver`=1 and `frm_type[3:0]` equals `cfg_v2_type`; `frm_type[7:4]` is ignored. A layer-2 frame (`frm_udp`=0) then qualifies always, and a UDP frame qualifies only when `cfg_udp_en`=1.
- R4: With `cfg_ver`=0 and `cfg_udp_en`=0, no frame is ever captured.
- R5: A qualifying frame is stored in the lowest-numbered free slot. One cycle after the strobe, `cap_valid` is high for one cycle and `cap_slot` gives that slot. An occupied slot is never overwritten.
- R6: The stored value is `time_ns` at the clock edge that samples the strobe. Word address 2*i returns bits 31:0 of slot i and address 2*i+1 returns bits 63:32. Read data appears on `rd_data` the cycle after `rd_en`.
- R7: Word address 8 returns the status word. Bit i is 1 while slot i is occupied, and the upper bits are 0.
- R8: Reading address 2*i+1 frees slot i from the next cycle on. Reading address 2*i, or the status word, frees nothing.
- R9: When all slots are occupied, a qualifying frame is dropped: `cap_valid` stays low and no stored value or status bit changes.
- R10: While `cfg_enable`=0, no frame is captured and `cap_valid` stays low.
- R11: A non-qualifying strobe leaves `cap_valid` low and the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows captures |
| cfg_ver | input | 1 | Version to recognise: 0 = version 1, 1 = version 2 |
| cfg_udp_en | input | 1 | UDP recognition switch |
| cfg_v1_type | input | 8 | Message type matched for version 1 |
| cfg_v2_type | input | 4 | Message type matched for version 2 |
| frm_valid | input | 1 | One-cycle classification strobe |
| frm_ver | input | 1 | Frame version: 0 = version 1, 1 = version 2 |
| frm_udp | input | 1 | 1 = frame carried over UDP, 0 = layer 2 |
| frm_type | input | 8 | Frame message type |
| time_ns | input | 64 | Live nanosecond time |
| cap_valid | output | 1 | Frame was stamped |
| cap_slot | output | 2 | Slot holding the stamp |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Word address |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |

## Verification
The hardest state to reach is the full bank, where every slot is occupied and one is freed at a time. Only then does the drop rule apply. The reuse of a freed middle slot ahead of higher free ones is also only visible in that state. The stimulus fills all four slots with layer-2 version 2 frames, sends a fifth frame into the full bank, and then frees only slot 2 by reading its upper word. It first reads the lower word of slot 2 to show that this read alone frees nothing. Before that, a sweep runs through every combination of selected version, UDP switch, frame version, transport and type match, and releases each stamp right after checking it.

// File: rtl/rx_stamp_pkg.sv
package rx_stamp_pkg;

    localparam int TYPE_W    = 8;
    localparam int V2_TYPE_W = 4;

    typedef enum logic {
        VER_ONE = 1'b0,
        VER_TWO = 1'b1
    } ptp_ver_e;

    typedef struct packed {
        logic                 enable;
        ptp_ver_e             ver;
        logic                 udp_en;
        logic [TYPE_W-1:0]    v1_type;
        logic [V2_TYPE_W-1:0] v2_type;
    } filt_cfg_t;

    typedef struct packed {
        ptp_ver_e          ver;
        logic              udp;
        logic [TYPE_W-1:0] msg_type;
    } frame_cls_t;

    function automatic logic frame_hits(input filt_cfg_t c, input frame_cls_t f);
        logic v1_ok;
        logic v2_ok;
        v1_ok = (c.ver == VER_ONE) && (f.ver == VER_ONE) && f.udp && c.udp_en &&
                (f.msg_type == c.v1_type);
        v2_ok = (c.ver == VER_TWO) && (f.ver == VER_TWO) &&
                (f.msg_type[V2_TYPE_W-1:0] == c.v2_type) && (!f.udp || c.udp_en);
        return v1_ok || v2_ok;
    endfunction

endpackage

// File: rtl/rx_stamp_filter.sv
module rx_stamp_filter
    import rx_stamp_pkg::*;
(
    input  filt_cfg_t  cfg,
    input  frame_cls_t frm,
    input  logic       frm_valid,
    output logic       hit
);
    always_comb begin
        hit = frm_valid && cfg.enable && frame_hits(cfg, frm);
    end
endmodule

// File: rtl/rx_stamp_alloc.sv
module rx_stamp_alloc #(
    parameter int NSLOT = 4,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [NSLOT-1:0] held,
    output logic [NSLOT-1:0] grant,
    output logic [IDX_W-1:0] idx,
    output logic             any_free
);
    always_comb begin
        grant    = '0;
        idx      = '0;
        any_free = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (!any_free && !held[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_stamp_slot.sv
module rx_stamp_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    input  logic [TIME_W-1:0] time_in,
    output logic              held,
    output logic [TIME_W-1:0] stamp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= 1'b0;
            stamp <= '0;
        end else begin
            if (set) begin
                held  <= 1'b1;
                stamp <= time_in;
            end else if (clr) begin
                held  <= 1'b0;
            end
        end
    end

    // R5: a held slot is never written again
    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
        set |-> !held);

    // R9: stored value stays put while no new capture targets this slot
    assert_stamp_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (held && !set) |=> $stable(stamp));
endmodule

// File: rtl/rx_stamp_bank.sv
module rx_stamp_bank
    import rx_stamp_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int TIME_W = 64,
    parameter int REG_W  = 32,
    localparam int IDX_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int ADDR_W = $clog2(2 * NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_ver,
    input  logic              cfg_udp_en,
    input  logic [7:0]        cfg_v1_type,
    input  logic [3:0]        cfg_v2_type,
    input  logic              frm_valid,
    input  logic              frm_ver,
    input  logic              frm_udp,
    input  logic [7:0]        frm_type,
    input  logic [TIME_W-1:0] time_ns,
    output logic              cap_valid,
    output logic [IDX_W-1:0]  cap_slot,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data
);
    localparam int STAT_ADDR = 2 * NSLOT;

    filt_cfg_t  cfg;
    frame_cls_t frm;
    logic       hit;

    always_comb begin
        cfg.enable  = cfg_enable;
        cfg.ver     = ptp_ver_e'(cfg_ver);
        cfg.udp_en  = cfg_udp_en;
        cfg.v1_type = cfg_v1_type;
        cfg.v2_type = cfg_v2_type;
        frm.ver      = ptp_ver_e'(frm_ver);
        frm.udp      = frm_udp;
        frm.msg_type = frm_type;
    end

    rx_stamp_filter u_filter (
        .cfg       (cfg),
        .frm       (frm),
        .frm_valid (frm_valid),
        .hit       (hit)
    );

    logic [NSLOT-1:0]  held;
    logic [NSLOT-1:0]  grant;
    logic [IDX_W-1:0]  pick_idx;
    logic              any_free;
    logic              take;
    logic [NSLOT-1:0]  set_vec;
    logic [NSLOT-1:0]  clr_vec;
    logic [TIME_W-1:0] stamps [NSLOT];

    rx_stamp_alloc #(.NSLOT(NSLOT)) u_alloc (
        .held     (held),
        .grant    (grant),
        .idx      (pick_idx),
        .any_free (any_free)
    );

    always_comb begin
        take    = hit && any_free;
        set_vec = take ? grant : '0;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_comb begin
            clr_vec[g] = rd_en && (rd_addr == ADDR_W'(2 * g + 1));
        end

        rx_stamp_slot #(.TIME_W(TIME_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .set     (set_vec[g]),
            .clr     (clr_vec[g]),
            .time_in (time_ns),
            .held    (held[g]),
            .stamp   (stamps[g])
        );

        // R8: upper-word read of an occupied slot frees it
        assert_release_on_hi_R8: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[g] && held[g]) |=> !held[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_slot  <= '0;
        end else begin
            cap_valid <= take;
            if (take) begin
                cap_slot <= pick_idx;
            end
        end
    end

    logic [REG_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_addr == ADDR_W'(2 * i)) begin
                rd_mux = stamps[i][REG_W-1:0];
            end
            if (rd_addr == ADDR_W'(2 * i + 1)) begin
                rd_mux = stamps[i][TIME_W-1:REG_W];
            end
        end
        if (rd_addr == ADDR_W'(STAT_ADDR)) begin
            rd_mux = REG_W'(held);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    logic [NSLOT-1:0] slot_bit;
    logic [NSLOT-1:0] lower_bits;
    always_comb begin
        slot_bit   = NSLOT'(1) << cap_slot;
        lower_bits = slot_bit - NSLOT'(1);
    end

    // R5: the reported slot was free and every lower slot was occupied
    assert_lowest_free_R5: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> ((($past(held) & slot_bit) == '0) &&
                       (($past(held) & lower_bits) == lower_bits)));

    // R9: a full bank accepts nothing
    assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && (&held)) |=> !cap_valid);

    // R10: disabled bank never stamps
    assert_disabled_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !cap_valid);

    // R4: version 1 without UDP recognition never stamps
    assert_v1_no_udp_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ver && !cfg_udp_en) |=> !cap_valid);

    // R5: capture flag is a single-cycle pulse per strobe
    assert_cap_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !cap_valid);
endmodule

// File: tb/test_rx_stamp_bank.sv
`timescale 1ns/1ps
module test_rx_stamp_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic        cfg_ver = 1'b0;
    logic        cfg_udp_en = 1'b0;
    logic [7:0]  cfg_v1_type = 8'h00;
    logic [3:0]  cfg_v2_type = 4'h0;
    logic        frm_valid = 1'b0;
    logic        frm_ver = 1'b0;
    logic        frm_udp = 1'b0;
    logic [7:0]  frm_type = 8'h00;
    logic [63:0] time_ns = 64'd0;
    logic        cap_valid;
    logic [1:0]  cap_slot;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = 4'd0;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_stamp_bank i_rx_stamp_bank (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ver(cfg_ver),
        .cfg_udp_en(cfg_udp_en), .cfg_v1_type(cfg_v1_type), .cfg_v2_type(cfg_v2_type),
        .frm_valid(frm_valid), .frm_ver(frm_ver), .frm_udp(frm_udp), .frm_type(frm_type),
        .time_ns(time_ns), .cap_valid(cap_valid), .cap_slot(cap_slot),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic ver, input logic udp, input logic [7:0] ty,
                        input logic [63:0] t, output logic cv, output logic [1:0] cs);
        @(negedge clk);
        frm_valid = 1'b1; frm_ver = ver; frm_udp = udp; frm_type = ty; time_ns = t;
        @(posedge clk); #1;
        cv = cap_valid; cs = cap_slot;
        frm_valid = 1'b0;
        time_ns = ~t;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); #1;
        d = rd_data;
        rd_en = 1'b0;
    endtask

    function automatic logic [63:0] tval(input int n);
        return {32'hC0DE_0000 + n, 32'h00A5_0000 + 3 * n};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic        cv;
        logic [1:0]  cs;
        logic [31:0] d;
        int          n;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 cap_valid after reset", cap_valid, 0);
        rd(4'd8, d);
        chk("R1 status after reset", d, 0);

        cfg_enable = 1'b1; cfg_v1_type = 8'h5A; cfg_v2_type = 4'h3;
        n = 0;
        for (int cv_i = 0; cv_i < 2; cv_i++)
        for (int ue = 0; ue < 2; ue++)
        for (int fv = 0; fv < 2; fv++)
        for (int fu = 0; fu < 2; fu++)
        for (int tm = 0; tm < 3; tm++) begin
            logic [7:0]  ty;
            logic        exp;
            string       tag;
            cfg_ver = cv_i[0]; cfg_udp_en = ue[0];
            if (fv == 0) ty = (tm == 0) ? 8'h5A : (tm == 1) ? 8'h5B : 8'hDA;
            else         ty = (tm == 0) ? 8'h03 : (tm == 1) ? 8'h02 : 8'hF3;
            if (cv_i == 0)
                exp = (fv == 0) && (fu == 1) && (ue == 1) && (ty == 8'h5A);
            else
                exp = (fv == 1) && (ty[3:0] == 4'h3) && (fu == 0 || ue == 1);
            tag = (cv_i == 0 && ue == 0) ? "R4" : (cv_i == 0) ? "R2" : "R3";
            if (!exp) tag = {tag, "/R11"};
            n++;
            send(fv[0], fu[0], ty, tval(n), cv, cs);
            chk({tag, " cap_valid"}, cv, exp);
            if (exp) begin
                chk("R5 slot of first capture", cs, 0);
                rd(4'd0, d);
                chk("R6 low word", d, tval(n) & 64'hFFFF_FFFF);
                rd(4'd1, d);
                chk("R6 high word", d, tval(n) >> 32);
            end
            rd(4'd8, d);
            chk({tag, " status after sweep step"}, d, 0);
        end

        cfg_ver = 1'b1; cfg_udp_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            send(1'b1, 1'b0, 8'h03, tval(100 + k), cv, cs);
            chk("R5 fill cap_valid", cv, 1);
            chk("R5 fill slot order", cs, k);
        end
        rd(4'd8, d);
        chk("R7 status full", d, 32'hF);
        send(1'b1, 1'b0, 8'h03, tval(200), cv, cs);
        chk("R9 full drop cap_valid", cv, 0);
        rd(4'd8, d);
        chk("R9 status unchanged", d, 32'hF);
        rd(4'd0, d);
        chk("R9 slot0 kept", d, tval(100) & 64'hFFFF_FFFF);
        rd(4'd4, d);
        chk("R6 slot2 low", d, tval(102) & 64'hFFFF_FFFF);
        rd(4'd8, d);
        chk("R8 low read keeps slot", d, 32'hF);
        rd(4'd5, d);
        chk("R6 slot2 high", d, tval(102) >> 32);
        rd(4'd8, d);
        chk("R8 high read frees slot2", d, 32'hB);
        send(1'b1, 1'b1, 8'hA3, tval(300), cv, cs);
        chk("R5 reuse cap_valid", cv, 1);
        chk("R5 reuse freed slot", cs, 2);
        rd(4'd7, d);
        chk("R9 slot3 kept", d, tval(103) >> 32);
        rd(4'd5, d);
        chk("R6 new slot2 high", d, tval(300) >> 32);
        rd(4'd1, d);
        rd(4'd3, d);
        rd(4'd7, d);
        rd(4'd8, d);
        chk("R7 all freed", d, 0);

        cfg_enable = 1'b0;
        send(1'b1, 1'b0, 8'h03, tval(400), cv, cs);
        chk("R10 disabled cap_valid", cv, 0);
        rd(4'd8, d);
        chk("R10 disabled status", d, 0);
        cfg_enable = 1'b1;
        send(1'b1, 1'b0, 8'h03, tval(401), cv, cs);
        chk("R10 re-enabled capture", cv, 1);
        chk("R5 slot after re-enable", cs, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule